// File: doc/BRIEF.md
# Zero-Crossing and Soft Mute Gate

This block sits in a digital audio path and decides, sample by sample, how much of a signed sample stream reaches the next stage. It combines three ways of silencing the stream. A hard mute blanks the output at once. A soft mute scales each sample by a gain that ramps toward zero at a fast or a slow rate and ramps back up when released. A zero-crossing mute only switches state on a sample whose magnitude lies inside a programmable window around zero, so it never cuts a large excursion.

A register block supplies a control byte, and an optional clear strobe resets the zero-crossing state. An active-low pin gives a second soft-mute trigger that does not depend on the register path. Samples arrive with a valid strobe, one channel at a time. Each accepted sample leaves one clock later. Two status flags report the soft-mute request and the zero-crossing mute state.

Top module: `audio_mute_gate`

## Requirements
- R1: The window code in control bits [5:4] sets the zero-crossing threshold: code 0 gives 160, 1 gives 80, 2 gives 40 and 3 gives 20. A sample is inside the window when its absolute value is strictly below the threshold.
- R2: The zero-crossing mute state changes only on a valid sample that is inside the window. It then takes the value of control bit 3 (1 = muted), for both engaging and releasing. zm_flag shows this state, updated on the edge that accepts the sample.
- R3: While soft mute is requested, each valid sample lowers the gain by 1, or by 8 when control bit 1 is set. The gain stops at 0.
- R4: When control bit 2 (direct mute) is set, the output for that sample is 0, with no ramp and no wait for the window.
- R5: While soft mute is not requested, each valid sample raises the gain by the step selected by bit 1. The gain stops at full scale, 1024.
- R6: When neither direct mute nor zero-crossing mute applies, the output is floor(sample × gain / 1024), using the gain after that sample's update. When zero-crossing mute is engaged, the output is 0.
- R7: Soft mute is requested when control bit 0 is 1 or when smute_n is low. sm_flag shows the request one clock later.
- R8: A zc_clear pulse forces the zero-crossing mute state off, whatever the window or bit 3.
- R9: After reset, out_valid, out_sample, sm_flag and zm_flag are 0, and the gain is at full scale.
- R10: out_valid is in_valid delayed by one clock. Without a valid input, out_sample, the gain and the zero-crossing state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_byte | input | 8 | Mute control: bit0 soft request, bit1 fast slope, bit2 direct, bit3 zero-crossing mute, bits5:4 window code |
| zc_clear | input | 1 | Clears the zero-crossing mute state |
| smute_n | input | 1 | External soft-mute request, active low |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | Output strobe |
| out_sample | output | SAMPLE_W | Signed gained sample |
| sm_flag | output | 1 | Soft mute requested |
| zm_flag | output | 1 | Zero-crossing mute engaged |

## Verification
A sweep of every sample value from -175 to 175 under each of the four window codes, with the zero-crossing request toggling every five samples, places requests both just inside and just outside each threshold, for both signs. This tells an off-by-one threshold or a wrong code mapping apart from a correct one. Long soft-mute runs at both slopes, from the register bit and from the pin, drive the gain through both saturation points. A coarse sweep across the full sample range at a partial gain separates floor scaling from truncation toward zero. Direct mute set in the middle of a ramp, and idle cycles between samples, show that direct mute stays off the gain path and that state holds without a strobe.

// File: rtl/amg_pkg.sv
package amg_pkg;

   typedef struct packed {
      logic [1:0] win_code;
      logic       zc_en;
      logic       direct;
      logic       fast;
      logic       soft_req;
   } amg_ctl_t;

   function automatic amg_ctl_t amg_decode(input logic [7:0] b);
      amg_ctl_t c;
      c.soft_req = b[0];
      c.fast     = b[1];
      c.direct   = b[2];
      c.zc_en    = b[3];
      c.win_code = b[5:4];
      return c;
   endfunction

endpackage

// File: rtl/amg_window.sv
module amg_window #(
   parameter int SAMPLE_W = 16,
   parameter int WIN_BASE = 20,
   parameter int N_WIN    = 4
) (
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic [$clog2(N_WIN)-1:0]   code,
   output logic                       in_win
);
   localparam int MW = SAMPLE_W + 1;

   logic [MW-1:0] thr [N_WIN];
   logic [MW-1:0] mag;
   logic [MW-1:0] ext;

   for (genvar i = 0; i < N_WIN; i++) begin : g_thr
      localparam int T = WIN_BASE << (N_WIN - 1 - i);
      assign thr[i] = MW'(T);
   end

   assign ext    = {sample[SAMPLE_W-1], sample};
   assign mag    = sample[SAMPLE_W-1] ? (~ext + MW'(1)) : ext;
   assign in_win = mag < thr[code];

endmodule

// File: rtl/amg_zc.sv
module amg_zc (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic in_win,
   input  logic zc_en,
   input  logic clr,
   output logic zc_next,
   output logic zc_q
);
   always_comb begin
      if (clr)                   zc_next = 1'b0;
      else if (valid && in_win)  zc_next = zc_en;
      else                       zc_next = zc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zc_q <= 1'b0;
      else        zc_q <= zc_next;
   end

   a_r2_outside_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(valid && in_win)) |=> $stable(zc_q));
   a_r8_clear_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !zc_q);

endmodule

// File: rtl/amg_ramp.sv
module amg_ramp #(
   parameter int GAIN_W    = 10,
   parameter int FAST_STEP = 8,
   parameter int SLOW_STEP = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid,
   input  logic            req,
   input  logic            fast,
   output logic [GAIN_W:0] gain_next,
   output logic [GAIN_W:0] gain_q
);
   localparam int GW1 = GAIN_W + 1;
   localparam logic [GAIN_W:0] UNITY = GW1'(1 << GAIN_W);

   logic [GAIN_W:0] step;
   assign step = fast ? GW1'(FAST_STEP) : GW1'(SLOW_STEP);

   always_comb begin
      if (!valid)                     gain_next = gain_q;
      else if (req)                   gain_next = (gain_q > step) ? gain_q - step : '0;
      else if (UNITY - gain_q > step) gain_next = gain_q + step;
      else                            gain_next = UNITY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gain_q <= UNITY;
      else        gain_q <= gain_next;
   end

   a_r3_ramp_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && req) |=> gain_q <= $past(gain_q));
   a_r5_ramp_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !req) |=> gain_q >= $past(gain_q));
   a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      gain_q <= UNITY);
   a_r10_idle_gain_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(gain_q));

endmodule

// File: rtl/amg_scale.sv
module amg_scale #(
   parameter int SAMPLE_W = 16,
   parameter int GAIN_W   = 10
) (
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic [GAIN_W:0]            gain,
   output logic signed [SAMPLE_W-1:0] scaled
);
   localparam int PW = SAMPLE_W + GAIN_W + 2;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shifted;

   assign prod    = PW'(sample) * PW'($signed({1'b0, gain}));
   assign shifted = prod >>> GAIN_W;
   assign scaled  = shifted[SAMPLE_W-1:0];

endmodule

// File: rtl/audio_mute_gate.sv
module audio_mute_gate
   import amg_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter int GAIN_W    = 10,
   parameter int FAST_STEP = 8,
   parameter int SLOW_STEP = 1,
   parameter int WIN_BASE  = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [7:0]          ctl_byte,
   input  logic                zc_clear,
   input  logic                smute_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic                sm_flag,
   output logic                zm_flag
);
   localparam int N_WIN = 4;

   if (SAMPLE_W < 8) begin : g_chk_w
      $error("SAMPLE_W too small");
   end
   if ((WIN_BASE << (N_WIN - 1)) >= (1 << (SAMPLE_W - 1))) begin : g_chk_win
      $error("largest window exceeds sample range");
   end
   if (FAST_STEP < 1 || SLOW_STEP < 1 || FAST_STEP > (1 << GAIN_W)) begin : g_chk_step
      $error("ramp steps out of range");
   end

   amg_ctl_t ctl;
   logic     req;
   logic     in_win;
   logic     zc_next;
   logic     zc_q;
   logic [GAIN_W:0]            gain_next;
   logic [GAIN_W:0]            gain_q;
   logic signed [SAMPLE_W-1:0] scaled;

   assign ctl = amg_decode(ctl_byte);
   assign req = ctl.soft_req | ~smute_n;

   amg_window #(.SAMPLE_W(SAMPLE_W), .WIN_BASE(WIN_BASE), .N_WIN(N_WIN)) u_win (
      .sample (in_sample),
      .code   (ctl.win_code),
      .in_win (in_win)
   );

   amg_zc u_zc (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (in_valid),
      .in_win  (in_win),
      .zc_en   (ctl.zc_en),
      .clr     (zc_clear),
      .zc_next (zc_next),
      .zc_q    (zc_q)
   );

   amg_ramp #(.GAIN_W(GAIN_W), .FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP)) u_ramp (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (in_valid),
      .req       (req),
      .fast      (ctl.fast),
      .gain_next (gain_next),
      .gain_q    (gain_q)
   );

   amg_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
      .sample (in_sample),
      .gain   (gain_next),
      .scaled (scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
         sm_flag    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         sm_flag   <= req;
         if (in_valid)
            out_sample <= (ctl.direct || zc_next) ? '0 : scaled;
      end
   end

   assign zm_flag = zc_q;

   a_r4_direct_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctl.direct) |=> out_sample == '0);
   a_r7_flag_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
      !smute_n |=> sm_flag);
   a_r10_strobe_delay: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r10_idle_output_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_sample));

endmodule

// File: tb/audio_mute_gate_test.sv
`timescale 1ns/1ps
module audio_mute_gate_test;
   localparam int SW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    ctl_byte = '0;
   logic          zc_clear = 1'b0;
   logic          smute_n = 1'b1;
   logic          in_valid = 1'b0;
   logic [SW-1:0] in_sample = '0;
   logic          out_valid;
   logic [SW-1:0] out_sample;
   logic          sm_flag;
   logic          zm_flag;

   always #4 clk = ~clk;

   audio_mute_gate uut (
      .clk(clk), .rst_n(rst_n), .ctl_byte(ctl_byte), .zc_clear(zc_clear),
      .smute_n(smute_n), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(out_valid), .out_sample(out_sample),
      .sm_flag(sm_flag), .zm_flag(zm_flag)
   );

   int     n_cmp = 0;
   int     n_bad = 0;
   longint m_gain = 1024;
   bit     m_zc = 0;
   longint m_out = 0;
   bit     done = 0;

   task automatic chk(string tag, string what, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic longint thr_of(int code);
      return longint'(20 << (3 - code));
   endfunction

   task automatic send(int s, logic [7:0] c, logic pin, logic clr, string tag);
      bit     req;
      longint step;
      longint mag;
      @(negedge clk);
      in_valid = 1'b1; in_sample = SW'(s); ctl_byte = c; smute_n = pin; zc_clear = clr;
      @(posedge clk); #1;
      req  = c[0] | ~pin;
      step = c[1] ? 8 : 1;
      if (req) m_gain = (m_gain > step) ? m_gain - step : 0;
      else     m_gain = (1024 - m_gain > step) ? m_gain + step : 1024;
      mag = (s < 0) ? -longint'(s) : longint'(s);
      if (clr)                         m_zc = 0;
      else if (mag < thr_of(int'(c[5:4]))) m_zc = c[3];
      m_out = (c[2] || m_zc) ? 0 : ((longint'(s) * m_gain) >>> 10);
      chk(tag, "out_sample", longint'($signed(out_sample)), m_out);
      chk("R10", "out_valid", longint'(out_valid), 1);
      chk("R2", "zm_flag", longint'(zm_flag), longint'(m_zc));
      chk("R7", "sm_flag", longint'(sm_flag), longint'(req));
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0; zc_clear = 1'b0;
         @(posedge clk); #1;
         chk("R10", "idle out_valid", longint'(out_valid), 0);
         chk("R10", "idle out_sample", longint'($signed(out_sample)), m_out);
         chk("R2", "idle zm_flag", longint'(zm_flag), longint'(m_zc));
      end
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R9", "reset out_valid", longint'(out_valid), 0);
      chk("R9", "reset out_sample", longint'(out_sample), 0);
      chk("R9", "reset sm_flag", longint'(sm_flag), 0);
      chk("R9", "reset zm_flag", longint'(zm_flag), 0);
      @(negedge clk); rst_n = 1'b1;
      // R9: full-scale gain shows as a pass-through sample
      send(12345, 8'h00, 1'b1, 1'b0, "R9");

      // R1 / R2: window sweep with toggling zero-crossing request
      for (int code = 0; code < 4; code++) begin
         send(1000, 8'h00, 1'b1, 1'b1, "R8");
         for (int s = -175; s <= 175; s++) begin
            logic [7:0] c;
            c = {2'b00, 2'(code), 1'(((s + 175) / 5) % 2), 3'b000};
            send(s, c, 1'b1, 1'b0, "R1");
         end
         idle(2);
      end

      // R8: clear while engaged, on an out-of-window sample
      send(3, 8'h08, 1'b1, 1'b0, "R2");
      send(5000, 8'h08, 1'b1, 1'b1, "R8");
      send(6000, 8'h08, 1'b1, 1'b0, "R8");
      send(2, 8'h00, 1'b1, 1'b0, "R2");

      // R3 / R5: slow ramp down to zero then back up
      for (int i = 0; i < 1100; i++) send((i * 977) % 60000 - 30000, 8'h01, 1'b1, 1'b0, "R3");
      for (int i = 0; i < 1100; i++) send((i * 613) % 60000 - 30000, 8'h00, 1'b1, 1'b0, "R5");
      // fast slope
      for (int i = 0; i < 140; i++) send(20000 - i * 150, 8'h03, 1'b1, 1'b0, "R3");
      idle(3);
      for (int i = 0; i < 140; i++) send(-20000 + i * 150, 8'h02, 1'b1, 1'b0, "R5");
      // R7: pin as the trigger
      for (int i = 0; i < 150; i++) send(31000 - i * 97, 8'h02, 1'b0, 1'b0, "R7");
      for (int i = 0; i < 150; i++) send(-31000 + i * 97, 8'h02, 1'b1, 1'b0, "R7");

      // R4: direct mute mid-ramp, gain path keeps moving
      for (int i = 0; i < 60; i++) send(15000 + i, (i % 3 == 0) ? 8'h05 : 8'h01, 1'b1, 1'b0, "R4");
      for (int i = 0; i < 30; i++) send(-15000 - i, (i % 2 == 0) ? 8'h04 : 8'h00, 1'b1, 1'b0, "R4");

      // R6: scaling across the full range at a partial gain
      for (int i = 0; i < 300; i++) send(i, 8'h01, 1'b1, 1'b0, "R3");
      for (int s = -32768; s <= 32767; s += 97) send(s, 8'h00, 1'b1, 1'b0, "R6");
      for (int s = -32768; s <= 32767; s += 331) send(s, 8'h01, 1'b1, 1'b0, "R6");
      idle(4);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule